// File: doc/BRIEF.md
# Programmable Serial Flash Sequencer

This block runs serial flash transactions from a small instruction table that software loads beforehand. The table holds sixteen sequences of eight packed 16-bit instructions each. A trigger starts execution at a chosen sequence, carrying a 24-bit flash address and a byte count. The sequencer then walks the instructions in order. It can emit opcode bytes, shift out the address, clock read data into a receive stream, and pull write data from a transmit stream. A write instruction stalls until the transmit stream has delivered every byte it owes.

The flash device sits behind a byte-wide valid/ready port. Every accepted byte returns one received byte in the same handshake. A select line frames each transaction. A stop instruction drops the select and raises a sticky completion flag, which clears when the next trigger is accepted. An idle output reports that no run is in progress.

Top module: `flash_seq`

## Requirements
- R1: After reset `idle` is 1, and `dev_cs`, `cmd_done`, `dev_valid` and `rx_valid` are 0.
- R2: Slot k (0..7) of sequence n is held in table word n*4 + k/2. Even slots use bits 15:0 and odd slots use bits 31:16. Within an instruction, bits 15:10 are the opcode and bits 7:0 are the operand. Bits 9:8 carry a pad count and have no effect.
- R3: A trigger accepted while `idle` is 1 runs `cmd_count`+1 sequences in order, starting at `cmd_index`. The sequence number wraps from 15 to 0.
- R4: Opcode 0x01 sends its operand as one device byte.
- R5: Opcode 0x02 sends three device bytes: address bits 23:16, then 15:8, then 7:0.
- R6: Opcode 0x09 clocks in N bytes. N is the remaining byte count, or the operand when that count is zero. It sends 0x00 for each byte and presents each returned byte on `rx_data` with `rx_valid`, in order. A read does not consume the byte count.
- R7: Opcode 0x08 forwards transmit-stream bytes to the device, one per handshake, and lowers the remaining count by one for each. While `tx_valid` is low it stalls without finishing the run. It moves on once the count reaches zero. With a zero count it sends nothing.
- R8: Opcode 0x00 lowers `dev_cs`, sets `cmd_done` and skips the rest of its sequence. Execution continues with the next loaded sequence, if any.
- R9: Every other opcode, including the 0x20-offset double-rate codes, is a no-operation, and execution continues.
- R10: When the last loaded sequence is exhausted, `idle` returns to 1 with `dev_cs` at 0. `cmd_done` is cleared by each accepted trigger and is 1 only if a stop ran.
- R11: A trigger that arrives while `idle` is 0 is ignored. The run in progress keeps its parameters and its byte stream.
- R12: `dev_cs` is 1 on every device byte transfer.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Instruction table write strobe |
| imem_addr | input | 6 | Instruction table word index |
| imem_wdata | input | 32 | Instruction table write word |
| cmd_addr | input | 24 | Flash address for the run |
| cmd_size | input | 16 | Byte count for the run |
| cmd_index | input | 4 | First sequence of the run |
| cmd_count | input | 3 | Number of sequences minus one |
| trigger | input | 1 | Start a run (taken only when idle) |
| idle | output | 1 | No run in progress |
| cmd_done | output | 1 | Sticky flag set by a stop instruction |
| tx_valid | input | 1 | Transmit stream byte available |
| tx_data | input | 8 | Transmit stream byte |
| tx_ready | output | 1 | Transmit byte consumed when tx_valid also high |
| rx_valid | output | 1 | Received read byte strobe |
| rx_data | output | 8 | Received read byte |
| dev_cs | output | 1 | Device select, active high |
| dev_valid | output | 1 | Device byte offered |
| dev_wdata | output | 8 | Byte sent to the device |
| dev_ready | input | 1 | Device accepts the byte this cycle |
| dev_rdata | input | 8 | Byte returned by the device in the same handshake |

## Verification
The bench targets five corner cases:

- A stop in an early slot of a multi-sequence run. A design that ended the run there would lose the bytes of the following sequence.
- A run that starts at sequence 15. A design that did not wrap would read outside the table.
- A read with a zero count, which must fall back to the operand, and two reads in a row. A design that consumed the count would shorten the second read.
- A write held off by an empty transmit stream, with a second trigger fired during the stall. A design that finished early, or restarted on that trigger, would emit the wrong stream or address bytes.
- A table with no stop and scattered unsupported opcodes. A design that stalled on them would never go idle, and one that left the done flag standing would report a stop that never ran.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int IDX_W  = 4,
  parameter int SIZE_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              imem_we,
  input  logic [IDX_W+1:0]  imem_addr,
  input  logic [31:0]       imem_wdata,
  input  logic [23:0]       cmd_addr,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              trigger,
  output logic              idle,
  output logic              cmd_done,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              dev_cs,
  output logic              dev_valid,
  output logic [7:0]        dev_wdata,
  input  logic              dev_ready,
  input  logic [7:0]        dev_rdata
);

  localparam int WORDS = 4 << IDX_W;
  localparam logic [5:0] OP_STOP  = 6'h00;
  localparam logic [5:0] OP_CMD   = 6'h01;
  localparam logic [5:0] OP_RADDR = 6'h02;
  localparam logic [5:0] OP_WRITE = 6'h08;
  localparam logic [5:0] OP_READ  = 6'h09;

  typedef enum logic [2:0] {S_IDLE, S_DEC, S_CMD, S_ADDR, S_READ, S_WRITE} st_t;

  logic [31:0]       mem [WORDS];
  st_t               state;
  logic [IDX_W-1:0]  seq;
  logic [2:0]        slot;
  logic [CNT_W-1:0]  left;
  logic [SIZE_W-1:0] remain, cnt, rd_len;
  logic [23:0]       addr_q;
  logic              done_q, cs_q;
  logic [IDX_W+1:0]  widx;
  logic [5:0]        op;
  logic [7:0]        opnd;
  logic              xfer, adv, last;

  always_ff @(posedge clk)
    if (imem_we) mem[imem_addr] <= imem_wdata;

  assign widx   = {seq, slot[2:1]};
  assign op     = slot[0] ? mem[widx][31:26] : mem[widx][15:10];
  assign opnd   = slot[0] ? mem[widx][23:16] : mem[widx][7:0];
  assign rd_len = (remain != '0) ? remain : SIZE_W'(opnd);

  assign idle      = (state == S_IDLE);
  assign cmd_done  = done_q;
  assign dev_cs    = cs_q;
  assign dev_valid = (state == S_CMD) || (state == S_ADDR) || (state == S_READ) ||
                     (state == S_WRITE && tx_valid);
  assign xfer      = dev_valid && dev_ready;
  assign tx_ready  = (state == S_WRITE) && dev_ready;
  assign rx_valid  = xfer && (state == S_READ);
  assign rx_data   = dev_rdata;

  always_comb begin
    case (state)
      S_CMD:   dev_wdata = opnd;
      S_ADDR:  dev_wdata = (cnt[1:0] == 2'd2) ? addr_q[23:16] :
                           (cnt[1:0] == 2'd1) ? addr_q[15:8] : addr_q[7:0];
      S_WRITE: dev_wdata = tx_data;
      default: dev_wdata = 8'h00;
    endcase
  end

  always_comb begin
    case (state)
      S_DEC: begin
        case (op)
          OP_CMD, OP_RADDR: adv = 1'b0;
          OP_READ:          adv = (rd_len == '0);
          OP_WRITE:         adv = (remain == '0);
          default:          adv = 1'b1;
        endcase
      end
      S_CMD:   adv = xfer;
      S_ADDR:  adv = xfer && (cnt == '0);
      S_READ:  adv = xfer && (cnt == SIZE_W'(1));
      S_WRITE: adv = xfer && (remain == SIZE_W'(1));
      default: adv = 1'b0;
    endcase
  end

  assign last = adv && ((state == S_DEC && op == OP_STOP) || slot == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      seq    <= '0;
      slot   <= '0;
      left   <= '0;
      remain <= '0;
      cnt    <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (trigger) begin
          seq    <= cmd_index;
          slot   <= '0;
          left   <= cmd_count;
          remain <= cmd_size;
          addr_q <= cmd_addr;
          done_q <= 1'b0;
          state  <= S_DEC;
        end
        S_DEC: begin
          case (op)
            OP_STOP:  begin cs_q <= 1'b0; done_q <= 1'b1; end
            OP_CMD:   begin cs_q <= 1'b1; state <= S_CMD; end
            OP_RADDR: begin cs_q <= 1'b1; cnt <= SIZE_W'(2); state <= S_ADDR; end
            OP_READ:  if (rd_len != '0) begin cs_q <= 1'b1; cnt <= rd_len; state <= S_READ; end
            OP_WRITE: if (remain != '0) begin cs_q <= 1'b1; state <= S_WRITE; end
            default: ;
          endcase
        end
        S_ADDR, S_READ: if (xfer) cnt <= cnt - 1'b1;
        S_WRITE:        if (xfer) remain <= remain - 1'b1;
        default: ;
      endcase
      if (adv) begin
        if (last) begin
          if (left == '0) begin
            state <= S_IDLE;
            cs_q  <= 1'b0;
          end else begin
            seq   <= seq + 1'b1;
            left  <= left - 1'b1;
            slot  <= '0;
            state <= S_DEC;
          end
        end else begin
          slot  <= slot + 1'b1;
          state <= S_DEC;
        end
      end
    end
  end

  a_r12_cs_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |-> dev_cs);
  a_r10_idle_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !dev_cs);
  a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(addr_q));
  a_r8_done_drops_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_done) |-> !dev_cs);
  a_r6_read_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> dev_wdata == 8'h00);
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WRITE && xfer) |=> remain == $past(remain) - 1'b1);

endmodule

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, imem_we, trigger, idle, cmd_done;
  logic [5:0]  imem_addr;
  logic [31:0] imem_wdata;
  logic [23:0] cmd_addr;
  logic [15:0] cmd_size;
  logic [3:0]  cmd_index;
  logic [2:0]  cmd_count;
  logic        tx_valid, tx_ready, rx_valid, dev_cs, dev_valid, dev_ready;
  logic [7:0]  tx_data, rx_data, dev_wdata, dev_rdata;

  flash_seq u_flash_seq (.*);

  int checks = 0, fails = 0;
  logic [31:0] bmem [0:63];
  logic [7:0]  txsrc [0:255];
  logic [7:0]  exp_out [0:2047];
  logic [7:0]  exp_rx [0:2047];
  logic [7:0]  got_out [0:2047];
  logic [7:0]  got_rx [0:2047];
  int n_exp, n_exprx, exp_done, n_got, n_gotrx, tx_ptr;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int j);
    return 8'(j * 37 + 11);
  endfunction

  function automatic logic [15:0] ins(input int op, input int pad, input int od);
    return {op[5:0], pad[1:0], od[7:0]};
  endfunction

  task automatic put(input int sq, input int k, input logic [15:0] i);
    if (k % 2 == 1) bmem[sq*4 + k/2][31:16] = i;
    else            bmem[sq*4 + k/2][15:0]  = i;
  endtask

  function automatic logic [15:0] rnd_ins();
    int sel;
    sel = $urandom % 10;
    case (sel)
      0, 1:    return ins(0, $urandom % 4, $urandom);
      2, 9:    return ins(1, $urandom % 4, $urandom);
      3:       return ins(2, $urandom % 4, $urandom);
      4, 5:    return ins(9, $urandom % 4, $urandom % 8);
      6:       return ins(8, $urandom % 4, $urandom);
      7:       return ins(6'h0C, $urandom % 4, $urandom);
      default: return ins(6'h21, $urandom % 4, $urandom);
    endcase
  endfunction

  task automatic flush_mem();
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_addr = 6'(a); imem_wdata = bmem[a];
    end
    @(negedge clk);
    imem_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    if (n_exp < 2048) begin exp_out[n_exp] = b; n_exp++; end
  endtask

  task automatic model(input int idx, input int cnt, input logic [23:0] a, input int size);
    int rem, tp;
    rem = size; tp = 0; n_exp = 0; n_exprx = 0; exp_done = 0;
    for (int s = 0; s <= cnt; s++) begin
      int sq;
      sq = (idx + s) % 16;
      for (int k = 0; k < 8; k++) begin
        logic [15:0] h;
        int op, od;
        h  = (k % 2 == 1) ? bmem[sq*4 + k/2][31:16] : bmem[sq*4 + k/2][15:0];
        op = int'(h[15:10]);
        od = int'(h[7:0]);
        if (op == 0) begin exp_done = 1; break; end
        else if (op == 1) push(8'(od));
        else if (op == 2) begin push(a[23:16]); push(a[15:8]); push(a[7:0]); end
        else if (op == 9) begin
          int n;
          n = (rem != 0) ? rem : od;
          for (int m = 0; m < n; m++) begin
            exp_rx[n_exprx] = pat(n_exp); n_exprx++; push(8'h00);
          end
        end else if (op == 8) begin
          for (int m = 0; m < rem; m++) begin push(txsrc[tp]); tp++; end
          rem = 0;
        end
      end
    end
  endtask

  task automatic run(input int idx, input int cnt, input logic [23:0] a, input int size,
                     input int stall, input int stall_got, input bit retrig, input string req);
    int cyc, bad, badrx, csbad;
    bit tmo;
    for (int i = 0; i < 256; i++) txsrc[i] = 8'($urandom);
    model(idx, cnt, a, size);
    tx_ptr = 0; n_got = 0; n_gotrx = 0; csbad = 0; tmo = 0; cyc = 0;
    @(negedge clk);
    cmd_index = 4'(idx); cmd_count = 3'(cnt); cmd_addr = a; cmd_size = 16'(size);
    trigger = 1'b1; dev_ready = 1'b0; tx_valid = 1'b0;
    @(negedge clk);
    trigger = 1'b0;
    while (1) begin
      if (retrig && cyc == 5) begin
        trigger = 1'b1; cmd_addr = ~a; cmd_index = 4'(idx + 1); cmd_size = 16'(size + 2);
      end else trigger = 1'b0;
      dev_ready = ($urandom % 4) != 0;
      tx_valid  = (cyc < stall) ? 1'b0 : (($urandom % 3) != 0);
      tx_data   = txsrc[tx_ptr];
      dev_rdata = pat(n_got);
      #1;
      if (stall > 0 && cyc == stall - 1)
        chk(!idle && n_got == stall_got && !cmd_done, "R7", "stalled write state", n_got, stall_got);
      if (dev_valid && dev_ready) begin
        if (!dev_cs) csbad++;
        if (n_got < 2048) got_out[n_got] = dev_wdata;
        if (rx_valid && n_gotrx < 2048) begin got_rx[n_gotrx] = rx_data; n_gotrx++; end
        n_got++;
      end
      if (tx_valid && tx_ready) tx_ptr++;
      if (idle) break;
      cyc++;
      if (cyc > 20000) begin tmo = 1; break; end
      @(negedge clk);
    end
    trigger = 1'b0;
    chk(!tmo, req, "run finished", cyc, 0);
    chk(n_got == n_exp, req, "device byte count", n_got, n_exp);
    bad = 0;
    for (int i = 0; i < n_exp && i < n_got; i++)
      if (got_out[i] !== exp_out[i]) begin
        if (bad == 0) chk(0, req, $sformatf("device byte %0d", i), got_out[i], exp_out[i]);
        bad++;
      end
    if (bad == 0) chk(1, req, "device bytes", 0, 0);
    chk(n_gotrx == n_exprx, "R6", "read byte count", n_gotrx, n_exprx);
    badrx = 0;
    for (int i = 0; i < n_exprx && i < n_gotrx; i++)
      if (got_rx[i] !== exp_rx[i]) badrx++;
    chk(badrx == 0, "R6", "read byte values", badrx, 0);
    chk(csbad == 0, "R12", "select during transfers", csbad, 0);
    chk(cmd_done == exp_done[0], "R10", "done flag", cmd_done, exp_done);
    chk(!dev_cs, "R10", "select low when idle", dev_cs, 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; imem_we = 1'b0; imem_addr = '0; imem_wdata = '0; trigger = 1'b0;
    cmd_addr = '0; cmd_size = '0; cmd_index = '0; cmd_count = '0;
    tx_valid = 1'b0; tx_data = '0; dev_ready = 1'b0; dev_rdata = '0;
    for (int a = 0; a < 64; a++) bmem[a] = 32'h0;
    repeat (3) @(negedge clk);
    #1;
    chk(idle && !dev_cs && !cmd_done && !dev_valid && !rx_valid, "R1", "reset outputs",
        {idle, dev_cs, cmd_done, dev_valid, rx_valid}, 5'b10000);
    rst_n = 1'b1;

    // R4 R5 R2: pad bits set, odd and even slots
    put(3, 0, ins(1, 3, 8'h9F)); put(3, 1, ins(2, 2, 0)); put(3, 2, ins(0, 1, 0));
    flush_mem();
    run(3, 0, 24'h123456, 0, 0, 0, 0, "R5");

    // R6: zero count uses operand, then count 3 used twice
    put(0, 0, ins(1, 0, 8'h03)); put(0, 1, ins(9, 0, 5)); put(0, 2, ins(0, 0, 0));
    put(1, 0, ins(9, 0, 9)); put(1, 1, ins(9, 0, 1)); put(1, 2, ins(0, 0, 0));
    flush_mem();
    run(0, 0, 24'h0, 0, 0, 0, 0, "R6");
    run(1, 0, 24'h0, 3, 0, 0, 0, "R6");

    // R7 stall with R11 retrigger during the stall
    put(5, 0, ins(1, 0, 8'h02)); put(5, 1, ins(8, 0, 0)); put(5, 2, ins(2, 0, 0)); put(5, 3, ins(0, 0, 0));
    put(6, 0, ins(1, 0, 8'hEE));
    flush_mem();
    run(5, 0, 24'hA1B2C3, 4, 20, 1, 1, "R11");

    // R7 zero count write sends nothing
    put(4, 0, ins(8, 0, 0)); put(4, 1, ins(1, 0, 8'h44)); put(4, 2, ins(0, 0, 0));
    flush_mem();
    run(4, 0, 24'h0, 0, 0, 0, 0, "R7");

    // R3 R8: wrap 15 -> 0, stop skips rest and continues
    put(15, 0, ins(1, 0, 8'h11)); put(15, 1, ins(0, 0, 0)); put(15, 2, ins(1, 0, 8'h22));
    put(0, 0, ins(1, 0, 8'h33)); put(0, 1, ins(0, 0, 0));
    flush_mem();
    run(15, 1, 24'h0, 0, 0, 0, 0, "R8");
    chk(n_got == 2 && got_out[0] == 8'h11 && got_out[1] == 8'h33, "R3", "wrapped sequence order",
        n_got, 2);

    // R9 R10: no stop, unsupported opcodes, done cleared
    put(7, 0, ins(6'h0C, 0, 1)); put(7, 1, ins(1, 0, 8'h5A)); put(7, 2, ins(6'h21, 0, 2));
    put(7, 3, ins(6'h1F, 0, 3)); put(7, 4, ins(1, 0, 8'hA5)); put(7, 5, ins(6'h3F, 0, 4));
    put(7, 6, ins(6'h0B, 0, 5)); put(7, 7, ins(1, 0, 8'h77));
    flush_mem();
    run(7, 0, 24'h0, 0, 0, 0, 0, "R9");
    chk(idle && !cmd_done, "R10", "idle without stop", {idle, cmd_done}, 2'b10);

    for (int t = 0; t < 40; t++) begin
      for (int a = 0; a < 64; a++) bmem[a] = {rnd_ins(), rnd_ins()};
      flush_mem();
      run($urandom % 16, $urandom % 4, 24'($urandom), $urandom % 6, 0, 0, 0, "R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule